// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single access requests from a small 8-bit processor core into external bus cycles on a 13-bit address space. The low eight address bits and the data share one 8-bit bus. The upper five address bits have their own outputs. Each bus cycle is a fixed frame of five clocks. An address phase ends with an address strobe, so external logic can latch the low byte. A turnaround phase follows, then a two-clock data strobe. During the data strobe the shared bus carries write data from the block, or read data from the outside.

The core holds `req_i` together with the address, write data, direction and opcode-fetch flag until it sees `done_o`. A five-phase counter runs continuously and defines a fixed frame grid. A cycle can only begin where that grid returns to phase 0. The data strobe is issued on every access: the block applies no address decode. A low-power input freezes the sequencer and keeps both strobes low. A request that is pending or in flight resumes once the input is released.

Top module: `mxbus_seq`

## Requirements
- R1: A bus cycle occupies the five phases 0..4 of a free-running frame. `as_o` is high for exactly one clock (phase 1). `ds_o` is high for exactly two clocks (phases 3 and 4), rising two clocks after `as_o`. Successive cycles start a multiple of five clocks apart when low-power mode is not used in between.
- R2: While `as_o` is high, `ad_oe_o` is 1, `ad_o` equals address bits 7:0, and `addr_hi_o` equals address bits 12:8.
- R3: On a write cycle (`rd_i`=0), `rw_o` is 0 for the whole cycle. During `ds_o`, `ad_oe_o` is 1 and `ad_o` carries the write data.
- R4: On a read cycle (`rd_i`=1), `rw_o` is 1. `ad_oe_o` is 0 from phase 2 through the end of the data strobe. `rdata_o` holds the value of `ad_i` sampled at the clock edge that ends phase 4.
- R5: `rw_o` keeps the value set in phase 0 unchanged until the data strobe has ended.
- R6: `li_o` is high exactly while `ds_o` is high on a cycle requested with `fetch_i`=1, and is low at all other times.
- R7: `done_o` is a one-clock pulse in the clock after phase 4, four clocks after `as_o`.
- R8: While `lowpwr_i` is 1, `as_o`, `ds_o` and `li_o` stay low and the phase counter holds. A request pending at that time, or a cycle already in progress, completes normally after `lowpwr_i` returns to 0.
- R9: After an active-low reset, the block is idle: `as_o`, `ds_o`, `li_o`, `done_o` and `ad_oe_o` are 0, and `rw_o` is 1.
- R10: With no request pending and no cycle in progress, `as_o`, `ds_o`, `done_o` and `ad_oe_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until done_o |
| addr_i | input | 13 | Access address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | 1 = read, 0 = write |
| fetch_i | input | 1 | Access is an opcode fetch |
| lowpwr_i | input | 1 | Wait/stop mode: freezes the sequencer, strobes low |
| ad_i | input | 8 | Shared bus as seen at the pads |
| ad_o | output | 8 | Shared bus drive value (address low byte, then data) |
| ad_oe_o | output | 1 | Shared bus output enable |
| addr_hi_o | output | 5 | Address bits 12:8 |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rw_o | output | 1 | Direction, 1 = read, 0 = write |
| li_o | output | 1 | Opcode fetch indicator, inside the data strobe |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench targets bus turnaround on reads. If a design kept `ad_oe_o` high into phase 2 or into the data strobe, the pad drivers would fight the external device. The bench also freezes the sequencer in the turnaround phase of a cycle and before a cycle is launched. A wrong design would then emit a stray or doubled strobe, lose the request, or fail to complete it. Strobe positions are measured against the five-clock grid, so an off-by-one phase counter or a launch off the phase-0 boundary shows up as a wrong spacing. Read data is checked against the bus value applied during the strobe, which catches sampling at the wrong edge.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int LO_W    = DATA_W;
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int NUM_PH  = 5;
  localparam int PH_W    = $clog2(NUM_PH);

  typedef enum logic [PH_W-1:0] {
    PH_ADDR = 3'd0,
    PH_AS   = 3'd1,
    PH_TURN = 3'd2,
    PH_DS1  = 3'd3,
    PH_DS2  = 3'd4
  } ph_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              rd;
    logic              fetch;
  } bus_req_t;
endpackage

// File: rtl/mxbus_phase.sv
module mxbus_phase
  import mxbus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output ph_e  ph_o,
  output logic frame_end_o
);
  ph_e ph_q, ph_d;

  always_comb begin
    unique case (ph_q)
      PH_ADDR: ph_d = PH_AS;
      PH_AS:   ph_d = PH_TURN;
      PH_TURN: ph_d = PH_DS1;
      PH_DS1:  ph_d = PH_DS2;
      default: ph_d = PH_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= PH_ADDR;
    else if (step_i) ph_q <= ph_d;
  end

  assign ph_o        = ph_q;
  assign frame_end_o = step_i && (ph_q == PH_DS2);

  AST_PH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_DS2); // R1
  AST_PH_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ph_q)); // R8
endmodule

// File: rtl/mxbus_launch.sv
module mxbus_launch
  import mxbus_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     frame_end_i,
  input  ph_e      ph_i,
  input  logic     req_i,
  input  bus_req_t nxt_i,
  output logic     active_o,
  output bus_req_t cur_o,
  output logic     done_o
);
  logic     active_q, done_q;
  bus_req_t cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cur_q    <= '0;
    end else begin
      done_q <= frame_end_i && active_q;
      if (frame_end_i) begin
        if (active_q) begin
          active_q <= 1'b0;
        end else if (req_i) begin
          // launch only on a phase-0 boundary; a finishing cycle forces one idle frame
          active_q <= 1'b1;
          cur_q    <= nxt_i;
        end
      end
    end
  end

  assign active_o = active_q;
  assign cur_o    = cur_q;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_LAUNCH_PH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> ph_i == PH_ADDR); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) |-> $stable(cur_q)); // R5
endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
  import mxbus_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lowpwr_i,
  input  ph_e             ph_i,
  input  logic            active_i,
  input  bus_req_t        cur_i,
  output logic            as_o,
  output logic            ds_o,
  output logic            li_o,
  output logic            rw_o,
  output logic            oe_o,
  output logic [LO_W-1:0] ad_o,
  output logic [HI_W-1:0] hi_o
);
  logic live, addr_ph, data_ph;

  always_comb begin
    live    = active_i && !lowpwr_i;
    addr_ph = (ph_i == PH_ADDR) || (ph_i == PH_AS);
    data_ph = (ph_i == PH_DS1) || (ph_i == PH_DS2);
    as_o    = live && (ph_i == PH_AS);
    ds_o    = live && data_ph;
    li_o    = ds_o && cur_i.fetch;
    rw_o    = active_i ? cur_i.rd : 1'b1;
    // read cycles release the bus from the turnaround phase on
    oe_o    = active_i && (addr_ph || !cur_i.rd);
    ad_o    = addr_ph ? cur_i.addr[LO_W-1:0] : cur_i.wdata;
    hi_o    = active_i ? cur_i.addr[ADDR_W-1:LO_W] : '0;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_o && rw_o |-> !oe_o); // R4
  AST_LI_IN_DS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    li_o |-> ds_o); // R6
  AST_AS_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |-> oe_o); // R2
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              fetch_i,
  input  logic              lowpwr_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              as_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              li_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  ph_e      ph;
  logic     frame_end, active;
  bus_req_t nxt, cur;
  logic [DATA_W-1:0] rdata_q;

  assign nxt = '{addr: addr_i, wdata: wdata_i, rd: rd_i, fetch: fetch_i};

  mxbus_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (!lowpwr_i),
    .ph_o        (ph),
    .frame_end_o (frame_end)
  );

  mxbus_launch u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .ph_i        (ph),
    .req_i       (req_i),
    .nxt_i       (nxt),
    .active_o    (active),
    .cur_o       (cur),
    .done_o      (done_o)
  );

  mxbus_drive u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lowpwr_i (lowpwr_i),
    .ph_i     (ph),
    .active_i (active),
    .cur_i    (cur),
    .as_o     (as_o),
    .ds_o     (ds_o),
    .li_o     (li_o),
    .rw_o     (rw_o),
    .oe_o     (ad_oe_o),
    .ad_o     (ad_o),
    .hi_o     (addr_hi_o)
  );

  // sample on the falling data strobe, i.e. the edge that closes phase 4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_q <= '0;
    else if (frame_end && active && cur.rd) rdata_q <= ad_i;
  end
  assign rdata_o = rdata_q;

  AST_RW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_o |-> $stable(rw_o)); // R5
  AST_LOWPWR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i && $past(lowpwr_i) |-> !done_o); // R8
endmodule

// File: tb/tb_mxbus_seq.sv
module tb_mxbus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic        fetch = 1'b0;
  logic        lowpwr = 1'b0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_o, rdata;
  logic        ad_oe, as_s, ds_s, rw_s, li_s, done;
  logic [4:0]  addr_hi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_as = -1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mxbus_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .fetch_i(fetch), .lowpwr_i(lowpwr), .ad_i(ad_in),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .addr_hi_o(addr_hi), .as_o(as_s), .ds_o(ds_s),
    .rw_o(rw_s), .li_o(li_s), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit exp_oe_ds(input bit r);
    return !r;
  endfunction

  function automatic bit exp_rw(input bit r);
    return r;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!as_s && !ds_s && !done && !ad_oe, "R10", "idle bus quiet",
          {as_s, ds_s, done, ad_oe}, 0);
    end
  endtask

  // lp_mode: 0 none, 1 low power before launch, 2 low power in turnaround
  task automatic run_txn(input logic [12:0] a, input logic [7:0] wd, input bit r,
                         input bit f, input logic [7:0] rv, input int lp_mode);
    int as_n = 0, ds_n = 0, as_t = -1, ds_t = -1, done_t = -1;
    bit got = 0, lp_done = 0;
    @(negedge clk);
    addr = a; wdata = wd; rd = r; fetch = f; ad_in = rv; req = 1'b1;
    if (lp_mode == 1) begin
      lowpwr = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        chk(!as_s && !ds_s && !li_s && !done, "R8", "quiet while pending",
            {as_s, ds_s, li_s, done}, 0);
      end
      lowpwr = 1'b0;
    end
    for (int k = 0; k < 80 && !got; k++) begin
      @(negedge clk);
      if (as_s) begin
        as_n++;
        if (as_t < 0) as_t = cyc;
        chk(ad_oe == 1'b1, "R2", "oe at as", ad_oe, 1);
        chk(ad_o == a[7:0], "R2", "low addr at as", ad_o, a[7:0]);
        chk(addr_hi == a[12:8], "R2", "high addr", addr_hi, a[12:8]);
        chk(rw_s == exp_rw(r), "R5", "rw at as", rw_s, exp_rw(r));
      end
      if (ds_s) begin
        ds_n++;
        if (ds_t < 0) ds_t = cyc;
        chk(rw_s == exp_rw(r), "R5", "rw in ds", rw_s, exp_rw(r));
        chk(ad_oe == exp_oe_ds(r), r ? "R4" : "R3", "oe in ds", ad_oe, exp_oe_ds(r));
        if (!r) chk(ad_o == wd, "R3", "write data", ad_o, wd);
        chk(li_s == f, "R6", "li in ds", li_s, f);
      end else begin
        chk(li_s == 1'b0, "R6", "li outside ds", li_s, 0);
      end
      if (r && as_t >= 0 && ds_t < 0 && !as_s)
        chk(ad_oe == 1'b0, "R4", "oe off in turnaround", ad_oe, 0);
      if (lp_mode == 2 && as_t >= 0 && !lp_done && cyc == as_t + 1) begin
        lowpwr = 1'b1;
        for (int i = 0; i < 7; i++) begin
          @(negedge clk);
          chk(!as_s && !ds_s && !li_s && !done, "R8", "quiet mid cycle",
              {as_s, ds_s, li_s, done}, 0);
          if (r) chk(ad_oe == 1'b0, "R4", "oe off while frozen", ad_oe, 0);
        end
        lowpwr = 1'b0;
        lp_done = 1;
      end
      if (done) begin
        got = 1;
        done_t = cyc;
        if (r) chk(rdata == rv, "R4", "read data", rdata, rv);
        req = 1'b0;
      end
    end
    chk(got, "R7", "done seen", got, 1);
    chk(as_n == 1, "R1", "as width", as_n, 1);
    chk(ds_n == 2, "R1", "ds width", ds_n, 2);
    if (lp_mode != 2) begin
      chk(ds_t - as_t == 2, "R1", "as to ds", ds_t - as_t, 2);
      chk(done_t - as_t == 4, "R7", "as to done", done_t - as_t, 4);
    end
    if (lp_mode == 0 && prev_as >= 0)
      chk((as_t - prev_as) % 5 == 0, "R1", "frame grid", (as_t - prev_as) % 5, 0);
    prev_as = (lp_mode == 2) ? -1 : as_t;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one clock", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    chk(!as_s && !ds_s && !li_s && !done && !ad_oe && rw_s, "R9", "reset idle",
        {as_s, ds_s, li_s, done, ad_oe, rw_s}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!as_s && !ds_s && !done && !ad_oe && rw_s, "R9", "idle after reset",
        {as_s, ds_s, done, ad_oe, rw_s}, 1);
    idle(7);
    run_txn(13'h0000, 8'hA5, 1'b0, 1'b0, 8'h00, 0);
    run_txn(13'h1FFF, 8'h00, 1'b1, 1'b1, 8'h3C, 0);
    run_txn(13'h0A55, 8'h00, 1'b1, 1'b0, 8'hFF, 1);
    run_txn(13'h15AA, 8'h5A, 1'b0, 1'b1, 8'h00, 2);
    run_txn(13'h0123, 8'h00, 1'b1, 1'b0, 8'h81, 2);
    run_txn(13'h1E0F, 8'hC3, 1'b0, 1'b0, 8'h00, 1);
    for (int n = 0; n < 40; n++) begin
      run_txn(13'($urandom()), 8'($urandom()), 1'($urandom()), 1'($urandom()),
              8'($urandom()), 0);
      if (($urandom() % 3) == 0) idle(1 + int'($urandom() % 9));
    end
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule